// File: doc/BRIEF.md
# Row/Column Addressed Content-Addressable Memory

This block is a small associative store of 64 words arranged as an 8 by 8 grid. A cell is picked by a 3-bit row address and a 3-bit column address. Each address drives its own one-hot decoder, and a cell is selected where a decoded row line and a decoded column line cross. Every cell holds an 8-bit word and a valid flag. Reset clears all valid flags, so a search can never hit a cell that was never written.

A two-bit operation code picks what a request does. A write stores a word into the addressed cell. A read returns the addressed cell on the data output. A search looks for a key across the whole grid. The search visits one cell per clock in row-major order, stops at the first valid cell that matches, and reports the row and column of that cell together with a hit flag. If no cell matches, it raises a miss flag instead.

Requests use a one-cycle start pulse. A one-cycle done pulse marks completion. A busy output is high while a search is in progress, and start pulses that arrive while it is high are dropped.

Top module: `grid_cam`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `hit`, `miss` and `rd_data` are 0 and every cell is invalid, so a search for any key, including 0x00, ends in a miss.
- R2: A start pulse with `op` = 01 (write) stores `wr_data` into cell (`row_sel`, `col_sel`), marks that cell valid and raises `done` in the next cycle.
- R3: A start pulse with `op` = 10 (read) loads the addressed cell onto `rd_data` and raises `done` in the next cycle. A cell that has never been written reads as 0x00.
- R4: A cell is selected only by the crossing of its decoded row line and decoded column line. Its row-major index is row*8+col, so row 2, column 3 is index 19. A write leaves every other cell unchanged.
- R5: A start pulse with `op` = 11 (search) scans the cells from index 0 upward, one per clock. If the lowest-index valid cell that matches is at index k, `done` and `hit` rise in the cycle k+2 after the start cycle, and `hit_row`/`hit_col` give that cell's row and column.
- R6: When no valid cell equals the key, the search raises `miss` with `done` in the cycle 65 after the start cycle. `hit` and `miss` are never high together.
- R7: A start pulse that arrives while `busy` is high is ignored: it writes nothing, reads nothing and does not change the search in progress.
- R8: A start pulse with `op` = 00 is ignored: it produces no `done` and changes no cell.
- R9: `rd_data` changes only when a read is accepted. `hit`, `miss`, `hit_row` and `hit_col` hold their values until the next accepted start, and every accepted start clears `hit` and `miss`.
- R10: `done` is high for exactly one cycle per accepted operation, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse; the other inputs are sampled on the same edge |
| op | input | 2 | 00 none, 01 write, 10 read, 11 search |
| row_sel | input | 3 | Row address |
| col_sel | input | 3 | Column address |
| wr_data | input | 8 | Word to store on a write |
| key | input | 8 | Word to look for on a search |
| busy | output | 1 | High while a search is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Result of the last read |
| hit | output | 1 | Last search found a match |
| miss | output | 1 | Last search found no match |
| hit_row | output | 3 | Row of the first matching cell |
| hit_col | output | 3 | Column of the first matching cell |

## Verification
The bench aims at the ends of the scan. It checks a match in cell 0 (latency 2), a match in the last cell (latency 65, the same as a full miss) and a key stored twice. A design with an off-by-one scan bound would miss the last cell. A design that did not stop early would report the later duplicate. It also searches for 0x00 straight after reset, which catches a design that matches on cells left uninitialised. It sends a write in the middle of a search and an op code of 00, and then reads the target cell back: a design that leaked either request would show the word there, and one that leaked the op-00 request would also give a stray done pulse. Row and column are checked as different cells ((2,3) against (3,2) and (2,4)), which catches swapped decoders.

// File: rtl/gcam_pkg.sv
package gcam_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_SEARCH = 2'b11
  } op_e;
endpackage

// File: rtl/gcam_onehot_dec.sv
module gcam_onehot_dec #(
  parameter int AW = 3
) (
  input  logic [AW-1:0]      sel,
  output logic [(1<<AW)-1:0] oh
);
  localparam int N = 1 << AW;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign oh[i] = (sel == AW'(i));
  end
endmodule

// File: rtl/gcam_cell_array.sv
module gcam_cell_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ROWS-1:0]               row_oh,
  input  logic [COLS-1:0]               col_oh,
  input  logic [DW-1:0]                 wdata,
  input  logic [$clog2(ROWS*COLS)-1:0]  rd_idx,
  output logic [DW-1:0]                 rd_word,
  output logic                          rd_valid
);
  localparam int DEPTH = ROWS * COLS;

  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] cell_we;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cell_we[r*COLS+c] = we & row_oh[r] & col_oh[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_q | cell_we;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (cell_we[i]) data_q[i] <= wdata;
    end
  end

  assign rd_word  = data_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/gcam_ctrl.sv
module gcam_ctrl
  import gcam_pkg::*;
#(
  parameter int ROW_AW = 3,
  parameter int COL_AW = 3,
  parameter int DW     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               op,
  input  logic [ROW_AW-1:0]        row_sel,
  input  logic [COL_AW-1:0]        col_sel,
  input  logic [DW-1:0]            key,
  input  logic [DW-1:0]            cell_word,
  input  logic                     cell_valid,
  output logic                     arr_we,
  output logic [ROW_AW+COL_AW-1:0] arr_idx,
  output logic                     busy,
  output logic                     done,
  output logic [DW-1:0]            rd_data,
  output logic                     hit,
  output logic                     miss,
  output logic [ROW_AW-1:0]        hit_row,
  output logic [COL_AW-1:0]        hit_col
);
  localparam int IDX_W = ROW_AW + COL_AW;
  localparam int DEPTH = 1 << IDX_W;

  logic             searching;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    key_q;
  logic             accept;
  logic             match;
  logic             last;
  op_e              op_t;

  assign op_t    = op_e'(op);
  assign accept  = start && !searching && (op_t != OP_NONE);
  assign arr_we  = accept && (op_t == OP_WRITE);
  assign arr_idx = searching ? idx_q : {row_sel, col_sel};
  assign match   = cell_valid && (cell_word == key_q);
  assign last    = (idx_q == IDX_W'(DEPTH - 1));
  assign busy    = searching;

  always_ff @(posedge clk) begin
    if (rst) begin
      searching <= 1'b0;
      idx_q     <= '0;
      key_q     <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      hit_row   <= '0;
      hit_col   <= '0;
    end else begin
      done <= 1'b0;
      if (searching) begin
        if (match) begin
          hit       <= 1'b1;
          hit_row   <= idx_q[IDX_W-1:COL_AW];
          hit_col   <= idx_q[COL_AW-1:0];
          done      <= 1'b1;
          searching <= 1'b0;
        end else if (last) begin
          miss      <= 1'b1;
          done      <= 1'b1;
          searching <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (accept) begin
        hit  <= 1'b0;
        miss <= 1'b0;
        case (op_t)
          OP_WRITE: done <= 1'b1;
          OP_READ: begin
            rd_data <= cell_valid ? cell_word : '0;
            done    <= 1'b1;
          end
          OP_SEARCH: begin
            searching <= 1'b1;
            idx_q     <= '0;
            key_q     <= key;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/grid_cam.sv
module grid_cam #(
  parameter int ROW_AW = 3,
  parameter int COL_AW = 3,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ROW_AW-1:0] row_sel,
  input  logic [COL_AW-1:0] col_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     key,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic              hit,
  output logic              miss,
  output logic [ROW_AW-1:0] hit_row,
  output logic [COL_AW-1:0] hit_col
);
  localparam int ROWS  = 1 << ROW_AW;
  localparam int COLS  = 1 << COL_AW;
  localparam int IDX_W = ROW_AW + COL_AW;

  logic [ROWS-1:0]  row_oh;
  logic [COLS-1:0]  col_oh;
  logic             arr_we;
  logic [IDX_W-1:0] arr_idx;
  logic [DW-1:0]    cell_word;
  logic             cell_valid;

  gcam_onehot_dec #(.AW(ROW_AW)) row_dec_i (.sel(row_sel), .oh(row_oh));
  gcam_onehot_dec #(.AW(COL_AW)) col_dec_i (.sel(col_sel), .oh(col_oh));

  gcam_cell_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) array_i (
    .clk      (clk),
    .rst      (rst),
    .we       (arr_we),
    .row_oh   (row_oh),
    .col_oh   (col_oh),
    .wdata    (wr_data),
    .rd_idx   (arr_idx),
    .rd_word  (cell_word),
    .rd_valid (cell_valid)
  );

  gcam_ctrl #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .DW(DW)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op         (op),
    .row_sel    (row_sel),
    .col_sel    (col_sel),
    .key        (key),
    .cell_word  (cell_word),
    .cell_valid (cell_valid),
    .arr_we     (arr_we),
    .arr_idx    (arr_idx),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data),
    .hit        (hit),
    .miss       (miss),
    .hit_row    (hit_row),
    .hit_col    (hit_col)
  );
endmodule

// File: rtl/gcam_checker.sv
module gcam_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    op,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rd_data,
  input logic          hit,
  input logic          miss
);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));

  assert_write_done_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b01) |=> done);

  assert_read_done_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b10) |=> done);

  assert_search_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b11) |=> busy);

  assert_busy_keeps_rd_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));

  assert_nop_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b00) |=> !done);

  assert_hit_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> done);

  assert_miss_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(miss) |-> done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind grid_cam gcam_checker #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .op      (op),
  .busy    (busy),
  .done    (done),
  .rd_data (rd_data),
  .hit     (hit),
  .miss    (miss)
);

// File: tb/grid_cam_tb_top.sv
module grid_cam_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [2:0] row_sel = '0, col_sel = '0;
  logic [7:0] wr_data = '0, key = '0;
  logic       busy, done, hit, miss;
  logic [7:0] rd_data;
  logic [2:0] hit_row, hit_col;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  grid_cam dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .row_sel(row_sel),
    .col_sel(col_sel), .wr_data(wr_data), .key(key), .busy(busy),
    .done(done), .rd_data(rd_data), .hit(hit), .miss(miss),
    .hit_row(hit_row), .hit_col(hit_col)
  );

  // behavioural reference model
  logic [7:0] mm [64];
  bit         mv [64];
  bit         e_busy, e_done, e_hit, e_miss;
  logic [7:0] e_rd;
  int         e_row, e_col, m_cnt, m_k;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mv[i] = 0;
      e_busy = 0; e_done = 0; e_hit = 0; e_miss = 0; e_rd = 0;
      e_row = 0; e_col = 0; m_cnt = 0; m_k = -1;
    end else begin
      e_done = 0;
      if (e_busy) begin
        if (m_cnt == 0) begin
          e_busy = 0; e_done = 1;
          if (m_k >= 0) begin e_hit = 1; e_row = m_k / 8; e_col = m_k % 8; end
          else e_miss = 1;
        end else m_cnt--;
      end else if (start && op != 2'b00) begin
        e_hit = 0; e_miss = 0;
        if (op == 2'b01) begin
          mm[row_sel*8+col_sel] = wr_data; mv[row_sel*8+col_sel] = 1; e_done = 1;
        end else if (op == 2'b10) begin
          e_rd = mv[row_sel*8+col_sel] ? mm[row_sel*8+col_sel] : 8'h00; e_done = 1;
        end else begin
          m_k = -1;
          for (int i = 0; i < 64; i++) if (m_k < 0 && mv[i] && mm[i] == key) m_k = i;
          m_cnt = (m_k >= 0) ? m_k : 63;
          e_busy = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy == e_busy, "R7 busy vs model", busy, e_busy);
      check(done == e_done, "R10 done vs model", done, e_done);
      check(rd_data == e_rd, "R3 rd_data vs model", rd_data, e_rd);
      check(hit == e_hit, "R5 hit vs model", hit, e_hit);
      check(miss == e_miss, "R6 miss vs model", miss, e_miss);
      if (e_hit) check({hit_row, hit_col} == {3'(e_row), 3'(e_col)},
                       "R5 hit position vs model", {hit_row, hit_col}, e_row*8+e_col);
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  task automatic do_op(input logic [1:0] m, input int r, input int c,
                       input logic [7:0] d, input logic [7:0] k, output int lat);
    op = m; row_sel = 3'(r); col_sel = 3'(c); wr_data = d; key = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!busy && !done && !hit && !miss && rd_data == 0, "R1 reset outputs",
          {busy, done, hit, miss}, 0);
    do_op(2'b11, 0, 0, 0, 8'h00, lat);
    check(miss && !hit && lat == 65, "R1 search after reset misses", lat, 65);

    // R2 write, R3 read, R4 distinct cells
    do_op(2'b01, 2, 3, 8'hA5, 0, lat);
    check(lat == 1, "R2 write latency", lat, 1);
    @(negedge clk);
    check(!done, "R10 done single pulse", done, 0);
    do_op(2'b10, 2, 3, 0, 0, lat);
    check(rd_data == 8'hA5 && lat == 1, "R3 read back", rd_data, 8'hA5);
    do_op(2'b10, 2, 4, 0, 0, lat);
    check(rd_data == 8'h00, "R4 neighbour column untouched", rd_data, 0);
    do_op(2'b10, 3, 2, 0, 0, lat);
    check(rd_data == 8'h00, "R4 transposed cell untouched", rd_data, 0);

    // R5 search hit and first match
    do_op(2'b11, 0, 0, 0, 8'hA5, lat);
    check(hit && hit_row == 2 && hit_col == 3, "R5 hit position", {hit_row, hit_col}, 19);
    check(lat == 21, "R5 hit latency index 19", lat, 21);
    do_op(2'b01, 0, 5, 8'hA5, 0, lat);
    do_op(2'b11, 0, 0, 0, 8'hA5, lat);
    check(hit && hit_row == 0 && hit_col == 5 && lat == 7, "R5 lowest match wins",
          {hit_row, hit_col}, 5);

    // R6 miss
    do_op(2'b11, 0, 0, 0, 8'h5A, lat);
    check(miss && !hit && lat == 65, "R6 miss latency", lat, 65);

    // R7 start while busy ignored
    op = 2'b11; key = 8'h77; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    op = 2'b01; row_sel = 3'd7; col_sel = 3'd7; wr_data = 8'h77; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check(miss && !hit, "R7 search unaffected by busy start", miss, 1);
    do_op(2'b10, 7, 7, 0, 0, lat);
    check(rd_data == 8'h00, "R7 busy write dropped", rd_data, 0);

    // R8 op 00 ignored
    do_op(2'b00, 1, 1, 8'h33, 0, lat);
    check(lat >= 200, "R8 no done for op 00", lat, 200);
    do_op(2'b10, 1, 1, 0, 0, lat);
    check(rd_data == 8'h00, "R8 op 00 wrote nothing", rd_data, 0);

    // R9 hold and clear
    do_op(2'b10, 2, 3, 0, 0, lat);
    repeat (5) @(negedge clk);
    check(rd_data == 8'hA5, "R9 rd_data holds", rd_data, 8'hA5);
    do_op(2'b11, 0, 0, 0, 8'hA5, lat);
    repeat (4) @(negedge clk);
    check(hit && hit_col == 5, "R9 hit holds", hit, 1);
    do_op(2'b01, 4, 4, 8'h10, 0, lat);
    check(!hit && !miss && rd_data == 8'hA5, "R9 start clears flags, keeps rd_data",
          {hit, miss}, 0);

    // full fill, scan boundaries
    for (int i = 0; i < 64; i++) do_op(2'b01, i / 8, i % 8, pat(i), 0, lat);
    do_op(2'b10, 7, 7, 0, 0, lat);
    check(rd_data == pat(63), "R4 last cell read", rd_data, pat(63));
    do_op(2'b11, 0, 0, 0, pat(0), lat);
    check(hit && lat == 2 && hit_row == 0 && hit_col == 0, "R5 first cell", lat, 2);
    do_op(2'b11, 0, 0, 0, pat(40), lat);
    check(hit && lat == 42 && hit_row == 5 && hit_col == 0, "R5 index 40", lat, 42);
    do_op(2'b11, 0, 0, 0, pat(63), lat);
    check(hit && lat == 65 && hit_row == 7 && hit_col == 7, "R5 last cell hit", lat, 65);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule